// File: doc/BRIEF.md
# Board Identification and Configuration Decoder

After reset this block confirms that the expected board is fitted and works out how its shared memory and interrupt line are set up. It reads a byte-wide identity port four times. Each byte carries one nibble of a 16-bit identity word together with the position of that nibble, so the reads can arrive in any order. If the assembled word matches the expected constant, the block fetches words from a configuration EEPROM through a simple request/acknowledge reader. From one word it decodes the memory window base and size. It then checks that the whole EEPROM sums to the identity constant, and finally translates a 3-bit interrupt field into an interrupt line number.

When every check passes, the block raises `done` and `cfg_valid` and presents the decoded configuration. This includes a flag that tells the rest of the chip to reach on-board memory through indirect (pointer/data port) access instead of a mapped window. If a check fails, the block raises `done` with a nonzero error code that names the first check to fail, and it then stays idle until the next reset.

Top module: `cfg_probe`

## Requirements
- R1: After reset the block pulses `id_rd` in exactly four cycles and samples `id_data` in each of those cycles. The nibble in bits [7:4] is placed at bit position 4×(bits [1:0]) of the identity word. The four nibbles are combined by bitwise OR, and bits [3:2] are ignored.
- R2: If the identity word differs from `BOARD_ID` (default 16'hBABA), the block ends with `err_code`=1 and issues no EEPROM request.
- R3: Only the low byte of EEPROM word 6 is decoded for memory. The index p of its lowest set bit gives `mem_base` = 0xC0000 + p×0x4000.
- R4: The byte shifted right by p selects the size. 0x01 gives `mem_size`=1 (16 KB), 0x03 gives 2 (32 KB), 0x07 gives 3 (48 KB) and 0x0F gives 4 (64 KB).
- R5: A memory byte of zero ends the block with `err_code`=2. Any other shifted value not listed in R4 ends it with `err_code`=3. No further EEPROM words are requested after either error.
- R6: The block then reads EEPROM words 0 to 63 in ascending order. If their sum modulo 2^16 differs from `BOARD_ID`, it ends with `err_code`=4.
- R7: The block then reads word 1. Its bits [15:13] index the table {0, 9, 3, 4, 5, 10, 11, 0}, and the entry becomes `irq_num`.
- R8: `use_indirect` is 1 exactly when the configuration is valid and the size is 16 KB.
- R9: `cfg_valid` rises only after all checks pass. While `cfg_valid` is low, `mem_base`, `mem_size`, `irq_num` and `use_indirect` read zero. `err_code` stays zero until a check fails.
- R10: Once `done` is high, the block makes no identity reads and no EEPROM requests, and all outputs hold until reset.
- R11: `ee_addr` stays stable while `ee_req` is high and `ee_ack` is low. Each cycle with both high completes one word transfer, and `ee_data` is sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rd | output | 1 | Identity port read strobe |
| id_data | input | 8 | Identity port byte, valid while `id_rd` is high |
| ee_req | output | 1 | EEPROM word request |
| ee_addr | output | AW | EEPROM word address |
| ee_ack | input | 1 | EEPROM word returned this cycle |
| ee_data | input | 16 | EEPROM word, valid with `ee_ack` |
| done | output | 1 | Probe finished, pass or fail |
| cfg_valid | output | 1 | All checks passed |
| err_code | output | 3 | First failing check: 1 identity, 2 empty memory byte, 3 bad size, 4 checksum |
| mem_base | output | 20 | Memory window base address |
| mem_size | output | 3 | Size code: 1=16 KB, 2=32 KB, 3=48 KB, 4=64 KB |
| irq_num | output | 4 | Translated interrupt line |
| use_indirect | output | 1 | Use indirect access to on-board memory |

## Verification
The assertions check several properties on every cycle. They cover the address hold of the EEPROM handshake, the zeroed configuration outputs while the result is not valid, and the mutual exclusion of a valid result and an error code. They also check that the block stays quiet and stable once finished, that the base address is page-aligned inside its window, and that the indirect flag agrees with the size code. Other behaviours can only be shown by the bench's scenarios against its behavioural model. These are the nibble placement and OR merging, the order of the 64-word checksum sweep, the lowest-set-bit decode of each memory byte, the interrupt table, and which error code the first failing check yields.

// File: rtl/cfg_probe.sv
module cfg_probe #(
  parameter logic [15:0] BOARD_ID = 16'hBABA,
  parameter int EE_WORDS = 64,
  parameter int MEM_WORD = 6,
  parameter int IRQ_WORD = 1,
  parameter int IRQ_LSB  = 13,
  localparam int AW = $clog2(EE_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          id_rd,
  input  logic [7:0]    id_data,
  output logic          ee_req,
  output logic [AW-1:0] ee_addr,
  input  logic          ee_ack,
  input  logic [15:0]   ee_data,
  output logic          done,
  output logic          cfg_valid,
  output logic [2:0]    err_code,
  output logic [19:0]   mem_base,
  output logic [2:0]    mem_size,
  output logic [3:0]    irq_num,
  output logic          use_indirect
);

  localparam logic [2:0] E_ID   = 3'd1;
  localparam logic [2:0] E_NONE = 3'd2;
  localparam logic [2:0] E_SIZE = 3'd3;
  localparam logic [2:0] E_SUM  = 3'd4;
  localparam logic [19:0] WIN_ORIGIN = 20'hC0000;

  typedef enum logic [2:0] {
    S_START, S_ID, S_IDCHK, S_MEM, S_SUM, S_SUMCHK, S_IRQ, S_END
  } state_t;

  state_t         st;
  logic [1:0]     nib_cnt;
  logic [15:0]    id_acc;
  logic [AW-1:0]  wcnt;
  logic [15:0]    sum_acc;
  logic [2:0]     err_q;
  logic [2:0]     page_q;
  logic [2:0]     size_q;
  logic [3:0]     irq_q;

  logic [2:0]     low_idx;
  logic           any_set;
  logic [7:0]     remnant;
  logic [2:0]     size_dec;
  logic [3:0]     irq_dec;
  logic           xfer;

  always_comb begin
    low_idx = 3'd0;
    any_set = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      if (ee_data[i]) begin
        low_idx = 3'(i);
        any_set = 1'b1;
      end
    end
  end

  assign remnant = ee_data[7:0] >> low_idx;

  always_comb begin
    case (remnant)
      8'h01:   size_dec = 3'd1;
      8'h03:   size_dec = 3'd2;
      8'h07:   size_dec = 3'd3;
      8'h0F:   size_dec = 3'd4;
      default: size_dec = 3'd0;
    endcase
  end

  always_comb begin
    case (ee_data[IRQ_LSB +: 3])
      3'd1:    irq_dec = 4'd9;
      3'd2:    irq_dec = 4'd3;
      3'd3:    irq_dec = 4'd4;
      3'd4:    irq_dec = 4'd5;
      3'd5:    irq_dec = 4'd10;
      3'd6:    irq_dec = 4'd11;
      default: irq_dec = 4'd0;
    endcase
  end

  assign id_rd  = (st == S_ID);
  assign ee_req = (st == S_MEM) || (st == S_SUM) || (st == S_IRQ);
  assign xfer   = ee_req && ee_ack;

  always_comb begin
    case (st)
      S_MEM:   ee_addr = AW'(MEM_WORD);
      S_IRQ:   ee_addr = AW'(IRQ_WORD);
      S_SUM:   ee_addr = wcnt;
      default: ee_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_START;
      nib_cnt <= '0;
      id_acc  <= '0;
      wcnt    <= '0;
      sum_acc <= '0;
      err_q   <= '0;
      page_q  <= '0;
      size_q  <= '0;
      irq_q   <= '0;
    end else begin
      case (st)
        S_START: st <= S_ID;
        S_ID: begin
          id_acc  <= id_acc | (16'(id_data[7:4]) << {id_data[1:0], 2'b00});
          nib_cnt <= nib_cnt + 2'd1;
          if (nib_cnt == 2'd3) st <= S_IDCHK;
        end
        S_IDCHK: begin
          if (id_acc == BOARD_ID) st <= S_MEM;
          else begin
            err_q <= E_ID;
            st    <= S_END;
          end
        end
        S_MEM: if (xfer) begin
          if (!any_set) begin
            err_q <= E_NONE;
            st    <= S_END;
          end else if (size_dec == 3'd0) begin
            err_q <= E_SIZE;
            st    <= S_END;
          end else begin
            page_q  <= low_idx;
            size_q  <= size_dec;
            wcnt    <= '0;
            sum_acc <= '0;
            st      <= S_SUM;
          end
        end
        S_SUM: if (xfer) begin
          sum_acc <= sum_acc + ee_data;
          wcnt    <= wcnt + 1'b1;
          if (wcnt == AW'(EE_WORDS - 1)) st <= S_SUMCHK;
        end
        S_SUMCHK: begin
          if (sum_acc == BOARD_ID) st <= S_IRQ;
          else begin
            err_q <= E_SUM;
            st    <= S_END;
          end
        end
        S_IRQ: if (xfer) begin
          irq_q <= irq_dec;
          st    <= S_END;
        end
        default: st <= S_END;
      endcase
    end
  end

  assign done         = (st == S_END);
  assign cfg_valid    = done && (err_q == 3'd0);
  assign err_code     = err_q;
  assign mem_base     = cfg_valid ? WIN_ORIGIN + 20'({page_q, 14'b0}) : 20'd0;
  assign mem_size     = cfg_valid ? size_q : 3'd0;
  assign irq_num      = cfg_valid ? irq_q : 4'd0;
  assign use_indirect = cfg_valid && (size_q == 3'd1);

endmodule

// File: rtl/cfg_probe_chk.sv
module cfg_probe_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          id_rd,
  input logic          ee_req,
  input logic [AW-1:0] ee_addr,
  input logic          ee_ack,
  input logic          done,
  input logic          cfg_valid,
  input logic [2:0]    err_code,
  input logic [19:0]   mem_base,
  input logic [2:0]    mem_size,
  input logic [3:0]    irq_num,
  input logic          use_indirect
);

  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr)));

  a_r9_cfg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> (mem_base == 20'd0 && mem_size == 3'd0 && irq_num == 4'd0 && !use_indirect));

  a_r9_valid_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (err_code == 3'd0 && done));

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ee_req && !id_rd));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(err_code) && $stable(cfg_valid) && $stable(mem_base)
              && $stable(mem_size) && $stable(irq_num)));

  a_r8_indirect: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (use_indirect == (mem_size == 3'd1)));

  a_r3_base_window: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (mem_base[13:0] == 14'd0 && mem_base[19:14] >= 6'h30 && mem_base[19:14] <= 6'h37));

endmodule

bind cfg_probe cfg_probe_chk #(.AW(AW)) u_chk (.*);

// File: tb/cfg_probe_test.sv
module cfg_probe_test;
  localparam logic [15:0] ID = 16'hBABA;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_rd;
  logic [7:0] id_data = '0;
  logic ee_req;
  logic [AW-1:0] ee_addr;
  logic ee_ack = 1'b0;
  logic [15:0] ee_data = '0;
  logic done, cfg_valid, use_indirect;
  logic [2:0] err_code, mem_size;
  logic [19:0] mem_base;
  logic [3:0] irq_num;

  cfg_probe uut (.*);

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [15:0] eem [64];
  logic [7:0] idb [4];
  int aq [$];
  int id_reads = 0;
  int lat = 0;
  int wt = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference comparison and stimulus, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!done)
        chk(!cfg_valid && err_code == 0 && mem_base == 0 && mem_size == 0 && irq_num == 0 && !use_indirect,
            "R9 outputs before done", {cfg_valid, err_code, mem_size}, 0);
      if (id_rd) begin
        id_data = idb[id_reads % 4];
        id_reads++;
      end
      ee_ack = 1'b0;
      if (ee_req) begin
        if (wt == 0) begin
          if (aq.size() == 0) chk(0, "R11 unexpected EEPROM request", ee_addr, 0);
          else begin
            int e;
            e = aq.pop_front();
            chk(ee_addr == AW'(e), "R11 R6 EEPROM address order", ee_addr, e);
          end
          ee_data = eem[ee_addr];
          ee_ack = 1'b1;
          wt = lat;
        end else wt--;
      end
    end
  end

  function automatic logic [7:0] idbyte(input logic [3:0] nib, input int pos);
    return {nib, 2'b10, 2'(pos)};
  endfunction

  task automatic prep(input logic [7:0] mb, input int irqf, input int delta);
    logic [15:0] s;
    s = 0;
    for (int i = 0; i < 64; i++) eem[i] = 16'(i * 16'h0371) ^ 16'h5A00;
    eem[6][7:0] = mb;
    eem[1][15:13] = 3'(irqf);
    for (int i = 0; i < 63; i++) s = s + eem[i];
    eem[63] = ID - s + 16'(delta);
  endtask

  task automatic good_id();
    idb[0] = idbyte(4'hA, 0); idb[1] = idbyte(4'hB, 1);
    idb[2] = idbyte(4'hA, 2); idb[3] = idbyte(4'hB, 3);
  endtask

  task automatic run(input string name, input int latency);
    logic [15:0] id, s;
    int e_err, e_size, e_irq, p;
    logic [19:0] e_base;
    logic [7:0] b, r;
    int tab [8] = '{0, 9, 3, 4, 5, 10, 11, 0};
    int n;
    logic [19:0] h_base; logic [2:0] h_err; logic h_valid;

    id = 0; e_err = 0; e_size = 0; e_irq = 0; e_base = 0; p = 0;
    for (int k = 0; k < 4; k++) id = id | (16'(idb[k][7:4]) << (4 * idb[k][1:0]));
    aq.delete();
    if (id != ID) e_err = 1;
    else begin
      aq.push_back(6);
      b = eem[6][7:0];
      if (b == 0) e_err = 2;
      else begin
        while (!b[p]) p++;
        r = b >> p;
        e_size = (r == 8'h01) ? 1 : (r == 8'h03) ? 2 : (r == 8'h07) ? 3 : (r == 8'h0F) ? 4 : 0;
        if (e_size == 0) e_err = 3;
        else begin
          s = 0;
          for (int i = 0; i < 64; i++) begin s = s + eem[i]; aq.push_back(i); end
          if (s != ID) e_err = 4;
          else begin
            aq.push_back(1);
            e_irq = tab[eem[1][15:13]];
            e_base = 20'hC0000 + 20'(p * 20'h4000);
          end
        end
      end
    end

    lat = latency;
    @(negedge clk);
    rst_n = 1'b0; id_reads = 0; wt = latency;
    repeat (2) @(negedge clk);
    chk(!done && !cfg_valid && !id_rd && !ee_req && err_code == 0, "R9 reset state",
        {done, cfg_valid, id_rd, ee_req}, 0);
    rst_n = 1'b1;
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done, "R10 done reached", done, 1);
    $display("scenario %s", name);
    chk(err_code == 3'(e_err), "R2 R5 R6 error code", err_code, e_err);
    chk(cfg_valid == (e_err == 0), "R9 valid flag", cfg_valid, e_err == 0);
    chk(id_reads == 4, "R1 identity read count", id_reads, 4);
    chk(mem_base == e_base, "R3 memory base", mem_base, e_base);
    chk(mem_size == 3'(e_err == 0 ? e_size : 0), "R4 size code", mem_size, e_err == 0 ? e_size : 0);
    chk(irq_num == 4'(e_irq), "R7 irq number", irq_num, e_irq);
    chk(use_indirect == (e_err == 0 && e_size == 1), "R8 indirect flag", use_indirect, e_err == 0 && e_size == 1);
    chk(aq.size() == 0, "R2 R11 outstanding expected requests", aq.size(), 0);
    h_base = mem_base; h_err = err_code; h_valid = cfg_valid;
    repeat (6) @(negedge clk);
    chk(done && mem_base == h_base && err_code == h_err && cfg_valid == h_valid && id_reads == 4,
        "R10 hold after done", {err_code, cfg_valid}, {h_err, h_valid});
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    good_id(); prep(8'h3C, 5, 0); run("64K page2", 1);
    idb[0] = idbyte(4'hB, 3); idb[1] = idbyte(4'hA, 0);
    idb[2] = idbyte(4'hA, 2); idb[3] = idbyte(4'hB, 1);
    prep(8'h80, 1, 0); run("16K page7 shuffled id", 0);
    good_id(); prep(8'h70, 7, 0); run("48K page4", 2);
    good_id(); prep(8'hC0, 0, 0); run("32K page6", 1);
    good_id(); prep(8'h01, 6, 0); run("16K page0", 0);
    good_id(); idb[2] = idbyte(4'h5, 2); prep(8'h3C, 5, 0); run("id mismatch", 0);
    idb[0] = idbyte(4'hA, 0); idb[1] = idbyte(4'hB, 0);
    idb[2] = idbyte(4'hA, 2); idb[3] = idbyte(4'hB, 3); run("duplicate nibble position", 1);
    good_id(); prep(8'h00, 5, 0); run("empty memory byte", 1);
    good_id(); prep(8'h14, 5, 0); run("bad size remnant", 0);
    good_id(); prep(8'h3C, 5, 1); run("checksum off by one", 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule